// File: doc/BRIEF.md
# Voltage Window Comparator Conditioner

This block cleans up the two raw comparator decisions of one supply-voltage monitor channel. The upper-threshold decision and the lower-threshold decision arrive asynchronously from analog comparators. Each passes through its own two-flop synchronizer and then a stability filter. The filter lets a new level through only after it has held steadily for a selectable time: 64 microseconds with filtering on, or 16 microseconds with filtering off.

From the two filtered decisions the block builds an in-range flag, which is true when the lower-threshold comparator is high and the upper-threshold comparator is low. A mode input chooses what the first output carries: the filtered upper decision, or the in-range flag. The second output always carries the filtered lower decision. Downstream logic can therefore tell an input that is below the range from one that is above it. The in-range flag is only meaningful when the upper threshold is set above the lower one.

Top module: `voltWinCond`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `monA` and `monB` are 0 whatever the comparator inputs are.
- R2: With `filtEn`=1, a comparator input change that is then held appears on the filtered signal at rising edge 64*CYC_PER_US+2, counting the first edge after the change as edge 1. Until then it does not appear.
- R3: With `filtEn`=0, the same latency is 16*CYC_PER_US+2 rising edges.
- R4: An input level that is held for fewer than N sampled edges (N = the selected 64 or 16 times CYC_PER_US) leaves the filtered signal unchanged, and any return to the old level restarts the count. A level held for exactly N edges passes.
- R5: With `winMode`=1, `monA` is 1 exactly when filtered B is 1 and filtered A is 0. For (A,B) held at 00, 01 and 11, `monA` reads 0, 1 and 0.
- R6: With `winMode`=0, `monA` equals the filtered A comparator.
- R7: `monB` equals the filtered B comparator in both modes of `winMode`.
- R8: A change on `winMode` selects the new source for `monA` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous reset, active high |
| cmpA | input | 1 | Raw upper-threshold comparator, asynchronous |
| cmpB | input | 1 | Raw lower-threshold comparator, asynchronous |
| filtEn | input | 1 | 1 selects the long filter time, 0 the short delay |
| winMode | input | 1 | 1 puts the in-range flag on monA, 0 the filtered A comparator |
| monA | output | 1 | Filtered A comparator or in-range flag |
| monB | output | 1 | Filtered B comparator |

## Verification
Directed edges on each comparator with the input held are used to count the exact latency in both filter settings. Pulses of exactly N-1 and N sampled edges separate a filter that counts correctly from one that is off by one. The three legal comparator states and the illegal A-high/B-low state are applied in both modes, which shows whether monA follows the window function or the raw A decision and whether monB stays on B. Random bursts of bouncing inputs, with random mode and filter changes, are compared every cycle against a bench model and expose counters that fail to restart or that mix up the channels.

// File: rtl/voltWinPkg.sv
package voltWinPkg;
  localparam int NUM_CMP = 2;   // index 0 = A (upper), 1 = B (lower)
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;

  typedef struct packed {
    logic [NUM_CMP-1:0] load;   // commit synchronized level to filtered level
  } winStrobeT;
endpackage

// File: rtl/winCtrl.sv
module winCtrl
  import voltWinPkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int LONG_US    = 64,
  parameter int SHORT_US   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               filtEn,
  input  logic [NUM_CMP-1:0] syncCmp,
  input  logic [NUM_CMP-1:0] filtCmp,
  output winStrobeT          strobe
);
  localparam int LONG_N  = LONG_US * CYC_PER_US;
  localparam int SHORT_N = SHORT_US * CYC_PER_US;
  localparam int CNT_W   = $clog2(LONG_N + 1);

  logic [CNT_W-1:0] limit;
  assign limit = filtEn ? CNT_W'(LONG_N) : CNT_W'(SHORT_N);

  for (genvar ch = 0; ch < NUM_CMP; ch++) begin : g_chan
    logic [CNT_W-1:0] holdCnt;
    logic             pending;
    logic             reached;

    assign pending = syncCmp[ch] != filtCmp[ch];
    assign reached = holdCnt >= (limit - CNT_W'(1));
    assign strobe.load[ch] = pending && reached;

    always_ff @(posedge clk) begin
      if (rst) begin
        holdCnt <= '0;
      end else if (!pending || reached) begin
        holdCnt <= '0;
      end else begin
        holdCnt <= holdCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/winData.sv
module winData
  import voltWinPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CMP-1:0] rawCmp,
  input  logic               winMode,
  input  winStrobeT          strobe,
  output logic [NUM_CMP-1:0] syncCmp,
  output logic [NUM_CMP-1:0] filtCmp,
  output logic               monA,
  output logic               monB
);
  logic [NUM_CMP-1:0] meta;
  logic               inRange;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta    <= '0;
      syncCmp <= '0;
    end else begin
      meta    <= rawCmp;
      syncCmp <= meta;
    end
  end

  for (genvar ch = 0; ch < NUM_CMP; ch++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst) begin
        filtCmp[ch] <= 1'b0;
      end else if (strobe.load[ch]) begin
        filtCmp[ch] <= syncCmp[ch];
      end
    end
  end

  assign inRange = filtCmp[IDX_B] & ~filtCmp[IDX_A];
  assign monA    = winMode ? inRange : filtCmp[IDX_A];
  assign monB    = filtCmp[IDX_B];
endmodule

// File: rtl/voltWinCond.sv
module voltWinCond
  import voltWinPkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int LONG_US    = 64,
  parameter int SHORT_US   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cmpA,
  input  logic cmpB,
  input  logic filtEn,
  input  logic winMode,
  output logic monA,
  output logic monB
);
  winStrobeT          strobe;
  logic [NUM_CMP-1:0] syncCmp;
  logic [NUM_CMP-1:0] filtCmp;

  winCtrl #(
    .CYC_PER_US(CYC_PER_US),
    .LONG_US   (LONG_US),
    .SHORT_US  (SHORT_US)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .filtEn (filtEn),
    .syncCmp(syncCmp),
    .filtCmp(filtCmp),
    .strobe (strobe)
  );

  winData u_data (
    .clk    (clk),
    .rst    (rst),
    .rawCmp ({cmpB, cmpA}),
    .winMode(winMode),
    .strobe (strobe),
    .syncCmp(syncCmp),
    .filtCmp(filtCmp),
    .monA   (monA),
    .monB   (monB)
  );
endmodule

// File: rtl/voltWinCondChk.sv
module voltWinCondChk #(
  parameter int CYC_PER_US = 100,
  parameter int SHORT_US   = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       winMode,
  input logic       monA,
  input logic       monB,
  input logic [1:0] syncCmp,
  input logic [1:0] filtCmp
);
  localparam int SHORT_N = SHORT_US * CYC_PER_US;

  logic [31:0] runA;
  logic [31:0] runB;

  always_ff @(posedge clk) begin
    if (rst) begin
      runA <= '0;
      runB <= '0;
    end else begin
      runA <= (syncCmp[0] != filtCmp[0]) ? runA + 32'd1 : 32'd0;
      runB <= (syncCmp[1] != filtCmp[1]) ? runB + 32'd1 : 32'd0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!monA && !monB));

  // R4
  follow_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (filtCmp[0] != $past(filtCmp[0])) |-> (filtCmp[0] == $past(syncCmp[0])));

  // R3
  min_hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    (filtCmp[0] != $past(filtCmp[0])) |-> ($past(runA) >= 32'(SHORT_N - 1)));

  // R3
  min_hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    (filtCmp[1] != $past(filtCmp[1])) |-> ($past(runB) >= 32'(SHORT_N - 1)));

  // R5
  window_needs_b_chk: assert property (@(posedge clk) disable iff (rst)
    (winMode && monA) |-> monB);
endmodule

bind voltWinCond voltWinCondChk #(
  .CYC_PER_US(CYC_PER_US),
  .SHORT_US  (SHORT_US)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .winMode(winMode),
  .monA   (monA),
  .monB   (monB),
  .syncCmp(syncCmp),
  .filtCmp(filtCmp)
);

// File: tb/test_voltWinCond.sv
module test_voltWinCond;
  localparam int C       = 1;
  localparam int LONG_N  = 64 * C;
  localparam int SHORT_N = 16 * C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmpA = 1'b0, cmpB = 1'b0, filtEn = 1'b1, winMode = 1'b0;
  logic monA, monB;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  always #5 clk = ~clk;

  voltWinCond #(.CYC_PER_US(C), .LONG_US(64), .SHORT_US(16)) i_voltWinCond (
    .clk(clk), .rst(rst), .cmpA(cmpA), .cmpB(cmpB),
    .filtEn(filtEn), .winMode(winMode), .monA(monA), .monB(monB)
  );

  // bench model derived from R2-R4: two sampling stages, then hold counter
  logic [1:0] m1, m2, mf;
  int mc [2];
  always @(posedge clk) begin
    if (rst) begin
      m1 <= '0; m2 <= '0; mf <= '0; mc[0] <= 0; mc[1] <= 0;
    end else begin
      m1 <= {cmpB, cmpA};
      m2 <= m1;
      for (int ch = 0; ch < 2; ch++) begin
        int lim;
        lim = filtEn ? LONG_N : SHORT_N;
        if (m2[ch] == mf[ch]) mc[ch] <= 0;
        else if (mc[ch] >= lim - 1) begin
          mf[ch] <= m2[ch];
          mc[ch] <= 0;
        end else mc[ch] <= mc[ch] + 1;
      end
    end
  end

  function automatic logic expA(logic fa, logic fb, logic wm);
    return wm ? (fb & ~fa) : fa;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic waitEdges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  // measure edges until monA rises after cmpA rises (monA direct mode)
  task automatic latencyA(int n, string tag);
    cmpA = 1'b1;
    waitEdges(n + 1);
    chk({tag, " not yet at N+1"}, monA, 1'b0);
    waitEdges(1);
    chk({tag, " at N+2"}, monA, 1'b1);
    cmpA = 1'b0;
    waitEdges(n + 4);
    chk({tag, " back low"}, monA, 1'b0);
  endtask

  initial begin
    // R1: inputs high during reset
    cmpA = 1'b1; cmpB = 1'b1;
    waitEdges(4);
    chk("R1 monA in reset", monA, 1'b0);
    chk("R1 monB in reset", monB, 1'b0);
    cmpA = 1'b0; cmpB = 1'b0;
    rst = 1'b0;
    waitEdges(1);
    chk("R1 monA after reset", monA, 1'b0);
    chk("R1 monB after reset", monB, 1'b0);
    waitEdges(4);

    // R2 / R3 latency, R6 direct mode
    filtEn = 1'b1; winMode = 1'b0;
    latencyA(LONG_N, "R2 R6 long latency");
    filtEn = 1'b0;
    latencyA(SHORT_N, "R3 R6 short latency");

    // R4 boundary: N-1 edges rejected, N edges pass (B channel, R7)
    cmpB = 1'b1; waitEdges(SHORT_N - 1); cmpB = 1'b0;
    waitEdges(SHORT_N + 6);
    chk("R4 pulse N-1 rejected", monB, 1'b0);
    cmpB = 1'b1; waitEdges(SHORT_N); cmpB = 1'b0;
    waitEdges(3);
    chk("R4 R7 pulse N passes", monB, 1'b1);
    waitEdges(SHORT_N + 3);
    chk("R4 R7 returns low", monB, 1'b0);
    // restart on bounce: two near-full pulses split by a gap
    cmpB = 1'b1; waitEdges(SHORT_N - 2); cmpB = 1'b0; waitEdges(1);
    cmpB = 1'b1; waitEdges(SHORT_N - 2); cmpB = 1'b0;
    waitEdges(SHORT_N + 6);
    chk("R4 bounce restarts count", monB, 1'b0);

    // R5 window table, R7 B in window mode, R8 mode switch without edge
    winMode = 1'b1;
    cmpA = 1'b0; cmpB = 1'b0; waitEdges(SHORT_N + 4);
    chk("R5 below range monA", monA, 1'b0);
    chk("R7 below range monB", monB, 1'b0);
    cmpB = 1'b1; waitEdges(SHORT_N + 4);
    chk("R5 inside range monA", monA, 1'b1);
    chk("R7 inside range monB", monB, 1'b1);
    winMode = 1'b0; #1;
    chk("R8 switch to direct", monA, 1'b0);
    winMode = 1'b1; #1;
    chk("R8 switch to window", monA, 1'b1);
    cmpA = 1'b1; waitEdges(SHORT_N + 4);
    chk("R5 above range monA", monA, 1'b0);
    chk("R7 above range monB", monB, 1'b1);
    winMode = 1'b0; #1;
    chk("R6 R8 direct shows A", monA, 1'b1);
    winMode = 1'b1;
    cmpB = 1'b0; waitEdges(SHORT_N + 4);
    chk("R5 A high B low monA", monA, 1'b0);
    cmpA = 1'b0; waitEdges(SHORT_N + 4);

    // random phase against model
    void'($urandom(32'd1234));
    for (int seg = 0; seg < 500; seg++) begin
      int hold;
      hold = ($urandom % 4 == 0) ? 1 + int'($urandom % 8) : 1 + int'($urandom % 80);
      if ($urandom % 2 == 0) cmpA = ~cmpA;
      if ($urandom % 3 == 0) cmpB = ~cmpB;
      if ($urandom % 25 == 0) filtEn = ~filtEn;
      if ($urandom % 10 == 0) winMode = ~winMode;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk(winMode ? "R5 R2 R3 R4 random monA" : "R6 R2 R3 R4 random monA",
            monA, expA(mf[0], mf[1], winMode));
        chk("R7 random monB", monB, mf[1]);
      end
    end

    summary();
    $finish;
  end
endmodule